// File: doc/BRIEF.md
# Long-Result Multiply-Accumulate Unit

This unit multiplies two 32-bit operands and can add the product to an accumulator. A 3-bit operation code selects one of six operations. Two of them give a truncated 32-bit result, one with a 32-bit addend. The other four give a full 64-bit product, unsigned or signed, either on its own or added to a 64-bit accumulator value. An optional flag update reports whether the result is negative and whether it is zero.

The multiply is iterative. It consumes 8 bits of the second operand per cycle, so a 32-bit operand takes four cycles. A caller pulses `start` with all inputs valid and waits for the one-cycle `done` pulse. The result and flags stay on the outputs until the next operation that completes. Codes that name no operation are refused at once through an error pulse.

Top module: `mac_long_unit`

## Requirements
- R1: Code 000 gives the low 32 bits of opa×opb on result[31:0], and result[63:32] reads 0.
- R2: Code 001 gives the low 32 bits of opa×opb+addend on result[31:0], and result[63:32] reads 0.
- R3: Code 100 gives the full unsigned 64-bit product of opa and opb on result[63:0].
- R4: Code 101 gives acc_in plus the unsigned 64-bit product, wrapping modulo 2^64 with no overflow indication.
- R5: Code 110 gives the two's-complement 64-bit product of opa and opb. Code 111 adds that signed product to acc_in modulo 2^64.
- R6: When set_flags is 1 at start, flag_n and flag_z are loaded in the cycle done is high. flag_n takes bit 31 of a 32-bit result or bit 63 of a 64-bit result. flag_z is 1 when that whole result is zero. With set_flags 0 both flags keep their values. result and the flags change only in a cycle where done is high.
- R7: Codes 010 and 011 raise op_error for exactly the one cycle after the start edge. They start no operation, produce no done, and leave result and the flags unchanged.
- R8: For an accepted legal start, busy is high from the next cycle. done is high for exactly one cycle, the 5th cycle after the start cycle, with busy low.
- R9: start is ignored while busy is high. No extra done appears, and the result belongs to the operation already running.
- R10: After reset, busy, done, op_error, flag_n, flag_z and result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when the unit is idle |
| op | input | 3 | Operation code, sampled with start |
| set_flags | input | 1 | Update flag_n/flag_z on completion |
| opa | input | 32 | First multiplicand |
| opb | input | 32 | Second multiplicand, consumed 8 bits per cycle |
| addend | input | 32 | Addend for code 001 |
| acc_in | input | 64 | Accumulator value for codes 101 and 111 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| op_error | output | 1 | One-cycle pulse for an illegal code |
| flag_n | output | 1 | Negative flag of the last flagged result |
| flag_z | output | 1 | Zero flag of the last flagged result |
| result | output | 64 | Result; upper half zero for 32-bit codes |

## Verification
The assertions assume that start, op and set_flags are never unknown once reset is released. They also assume that the operands matter only in the start cycle, because the unit captures them there. The stimulus changes every input on the falling edge and raises start for a single cycle. It sends a second start in the middle of a running operation only on purpose, to show that it is ignored. The operand values cover all-ones, the most negative value, zero results and accumulator wrap. The 8-bit slices of opb are chosen so that each slice's top bit is exercised in the signed codes.

// File: rtl/mac_long_unit.sv
module mac_long_unit #(
  parameter int W    = 32,
  parameter int STEP = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op,
  input  logic           set_flags,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic [W-1:0]   addend,
  input  logic [2*W-1:0] acc_in,
  output logic           busy,
  output logic           done,
  output logic           op_error,
  output logic           flag_n,
  output logic           flag_z,
  output logic [2*W-1:0] result
);
  localparam int DW    = 2 * W;
  localparam int NSTEP = W / STEP;
  localparam int CW    = $clog2(NSTEP + 1);

  logic [DW-1:0] acc_q, mcand_q;
  logic [W-1:0]  mplier_q;
  logic [CW-1:0] cnt_q;
  logic          long_q, sgn_q, sf_q;

  wire            legal = !(op[2] == 1'b0 && op[1] == 1'b1);
  wire [STEP-1:0] chunk = mplier_q[STEP-1:0];
  wire            last  = (cnt_q == CW'(NSTEP - 1));
  wire [DW-1:0]   pp    = mcand_q * DW'(chunk);
  wire [DW-1:0]   corr  = (sgn_q && last && chunk[STEP-1]) ? (mcand_q << STEP) : '0;
  wire [DW-1:0]   sum   = acc_q + pp - corr;
  wire [DW-1:0]   fin   = long_q ? sum : {{W{1'b0}}, sum[W-1:0]};
  wire            fin_n = long_q ? sum[DW-1] : sum[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      long_q   <= 1'b0;
      sgn_q    <= 1'b0;
      sf_q     <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      op_error <= 1'b0;
      flag_n   <= 1'b0;
      flag_z   <= 1'b0;
      result   <= '0;
    end else begin
      done     <= 1'b0;
      op_error <= 1'b0;
      if (!busy && start) begin
        if (legal) begin
          busy     <= 1'b1;
          cnt_q    <= '0;
          long_q   <= op[2];
          sgn_q    <= op[2] & op[1];
          sf_q     <= set_flags;
          mplier_q <= opb;
          mcand_q  <= (op[2] & op[1]) ? {{W{opa[W-1]}}, opa} : {{W{1'b0}}, opa};
          case (op)
            3'b001:         acc_q <= {{W{1'b0}}, addend};
            3'b101, 3'b111: acc_q <= acc_in;
            default:        acc_q <= '0;
          endcase
        end else begin
          op_error <= 1'b1;
        end
      end else if (busy) begin
        acc_q    <= sum;
        mcand_q  <= mcand_q << STEP;
        mplier_q <= mplier_q >> STEP;
        cnt_q    <= cnt_q + 1'b1;
        if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= fin;
          if (sf_q) begin
            flag_n <= fin_n;
            flag_z <= (fin == '0);
          end
        end
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !last) |=> (busy && !done));
  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) op_error |-> (!busy && !done));
  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) op_error |=> !op_error);
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(long_q) && $stable(sgn_q) && $stable(sf_q)));
  // R1
  mode32_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !long_q) |-> (result[DW-1:W] == '0));
  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(result) |-> done);
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({flag_n, flag_z}) |-> (done && sf_q));
endmodule

// File: tb/sim_mac_long_unit.sv
module sim_mac_long_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'b000;
  logic        set_flags = 1'b0;
  logic [31:0] opa = '0, opb = '0, addend = '0;
  logic [63:0] acc_in = '0;
  logic        busy, done, op_error, flag_n, flag_z;
  logic [63:0] result;

  mac_long_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .set_flags(set_flags),
    .opa(opa), .opb(opb), .addend(addend), .acc_in(acc_in),
    .busy(busy), .done(done), .op_error(op_error),
    .flag_n(flag_n), .flag_z(flag_z), .result(result)
  );

  always #5 clk = ~clk;

  typedef struct { logic [63:0] res; logic n; logic z; string tag; } item_t;
  item_t sb[$];

  int nchk = 0, nfail = 0, cyc = 0;
  logic        mn = 1'b0, mz = 1'b0;
  logic [63:0] last_res = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] rn, input logic [63:0] acc);
    logic signed [63:0] sp;
    logic [63:0] up;
    up = {32'b0, a} * {32'b0, b};
    sp = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    case (c)
      3'b000:  return {32'b0, up[31:0]};
      3'b001:  return {32'b0, up[31:0] + rn};
      3'b100:  return up;
      3'b101:  return up + acc;
      3'b110:  return sp;
      default: return sp + acc;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9 unexpected done", result, 64'hx);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(result === it.res, it.tag, result, it.res);
        chk({flag_n, flag_z} === {it.n, it.z}, {it.tag, " R6 flags"}, {62'b0, flag_n, flag_z}, {62'b0, it.n, it.z});
      end
    end
  end

  task automatic run_op(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] rn, input logic [63:0] acc, input bit sf,
                        input string tag, input bit intrude);
    item_t it;
    int lat;
    it.res = model(c, a, b, rn, acc);
    if (sf) begin
      mn = c[2] ? it.res[63] : it.res[31];
      mz = (it.res == 64'b0);
    end
    it.n = mn; it.z = mz; it.tag = tag;
    sb.push_back(it);
    last_res = it.res;
    @(negedge clk);
    op = c; opa = a; opb = b; addend = rn; acc_in = acc; set_flags = sf; start = 1'b1;
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    chk(busy === 1'b1, "R8 busy after start", {63'b0, busy}, 64'd1);
    if (intrude) begin
      @(negedge clk);
      lat++;
      op = 3'b000; opa = 32'd3; opb = 32'd3; set_flags = 1'b1; start = 1'b1;
      @(negedge clk);
      lat++;
      start = 1'b0;
    end
    while (done !== 1'b1 && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 5, "R8 latency", 64'(lat), 64'd5);
    @(negedge clk);
    chk(done === 1'b0, "R8 done width", {63'b0, done}, 64'd0);
  endtask

  task automatic run_bad(input logic [2:0] c);
    int seen;
    @(negedge clk);
    op = c; opa = 32'h1234; opb = 32'h55; set_flags = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(op_error === 1'b1 && busy === 1'b0, "R7 error pulse", {62'b0, op_error, busy}, 64'd2);
    @(negedge clk);
    chk(op_error === 1'b0, "R7 error width", {63'b0, op_error}, 64'd0);
    seen = 0;
    repeat (6) begin
      @(negedge clk);
      if (done === 1'b1 || busy === 1'b1) seen++;
    end
    chk(seen == 0, "R7 no operation", 64'(seen), 64'd0);
    chk(result === last_res, "R7 result unchanged", result, last_res);
    chk({flag_n, flag_z} === {mn, mz}, "R7 flags unchanged", {62'b0, flag_n, flag_z}, {62'b0, mn, mz});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, op_error, flag_n, flag_z} === 5'b0 && result === 64'b0, "R10 reset state",
        {59'b0, busy, done, op_error, flag_n, flag_z} | result, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(3'b000, 32'h12345678, 32'h9abcdef0, 32'h0, 64'h0, 1'b1, "R1 mul32", 1'b0);
    run_op(3'b000, 32'h0, 32'hdeadbeef, 32'h0, 64'h0, 1'b1, "R1 mul32 zero", 1'b0);
    run_op(3'b001, 32'hffffffff, 32'h2, 32'h5, 64'h0, 1'b1, "R2 mla32 wrap", 1'b0);
    run_op(3'b001, 32'h00010000, 32'h00008000, 32'h1, 64'h0, 1'b1, "R2 mla32 neg", 1'b0);
    run_op(3'b100, 32'hffffffff, 32'hffffffff, 32'h0, 64'h0, 1'b1, "R3 umull max", 1'b0);
    run_op(3'b100, 32'h80808080, 32'h80808080, 32'h0, 64'h0, 1'b0, "R3 umull nf", 1'b0);
    run_op(3'b101, 32'h1, 32'h1, 32'h0, 64'hffffffffffffffff, 1'b1, "R4 umlal wrap zero", 1'b0);
    run_op(3'b101, 32'hffffffff, 32'h10, 32'h0, 64'h0000000100000000, 1'b1, "R4 umlal", 1'b0);
    run_op(3'b110, 32'hffffffff, 32'hffffffff, 32'h0, 64'h0, 1'b1, "R5 smull m1m1", 1'b0);
    run_op(3'b110, 32'hfffffffb, 32'h7, 32'h0, 64'h0, 1'b1, "R5 smull neg", 1'b0);
    run_op(3'b110, 32'h80000000, 32'h80000000, 32'h0, 64'h0, 1'b1, "R5 smull minmin", 1'b0);
    run_op(3'b110, 32'h7fffffff, 32'h80808080, 32'h0, 64'h0, 1'b1, "R5 smull slices", 1'b0);
    run_op(3'b111, 32'hfffffffd, 32'h4, 32'h0, 64'h5, 1'b1, "R5 smlal", 1'b0);
    run_op(3'b111, 32'h80000000, 32'h7fffffff, 32'h0, 64'h8000000000000000, 1'b1, "R5 smlal wrap", 1'b0);
    run_op(3'b000, 32'h0, 32'h5, 32'h0, 64'h0, 1'b0, "R6 flags held", 1'b0);
    run_bad(3'b010);
    run_bad(3'b011);
    run_op(3'b100, 32'hcafef00d, 32'h01020304, 32'h0, 64'h0, 1'b1, "R9 busy start", 1'b1);
    repeat (8) @(negedge clk);
    chk(sb.size() == 0, "R9 queue drained", 64'(sb.size()), 64'd0);
    chk(result === last_res, "R9 result kept", result, last_res);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule